// File: doc/BRIEF.md
# Interrupt Priority Tracking Unit

This block keeps the interrupt state of a single processor core across 256 vectors. It holds two bitmaps, one for requests that are waiting and one for vectors the core is currently servicing. It also holds a task priority that software writes and a processor priority that the block derives from the task priority and the in-service set. Requests enter through a one-vector-per-cycle delivery port. The block offers the highest waiting vector to the core whenever that vector's priority class beats the processor priority.

The core takes an offered vector by pulsing an acknowledge strobe. That vector moves from the waiting set to the in-service set. An end-of-interrupt pulse retires the highest vector in service. A combinational read port returns any bitmap word or either priority register. Vectors 0 to 15 are reserved. A request for one of them is discarded and raises a sticky error flag.

Top module: `intr_prio_unit`

## Requirements
- R1: After reset, both bitmaps are empty, task and processor priority read 0, offer_valid is 0 and err_flag is 0.
- R2: A set request for vector v (16 to 255) sets bit v%32 of pending word v/32. Pending word k reads at offset k.
- R3: A set request for vector 0 to 15 changes no pending bit and sets err_flag. err_flag then stays 1 until reset.
- R4: offer_vector is the highest pending vector, and offer_valid is 1 only when (vector & 0xF0) is strictly greater than the processor priority. In the cycle after any edge that changes state, offer_valid is 0. The offer reflects the new state one cycle after that.
- R5: An ack while offer_valid is 1 sets the offered vector's in-service bit and clears its pending bit. An ack while offer_valid is 0 has no effect.
- R6: The processor priority equals the full task priority when the task priority's upper nibble is greater than or equal to the upper nibble of the highest in-service vector. Otherwise it equals that vector with its low nibble cleared. An empty in-service set counts as vector 0.
- R7: An end-of-interrupt pulse clears the highest set in-service bit. When the in-service set is empty, the pulse has no effect and does not suppress the offer.
- R8: A task-priority write loads all 8 data bits. The processor priority reflects the new value after the same clock edge.
- R9: Read offsets 0 to 7 return pending words 0 to 7, and offsets 8 to 15 return in-service words 0 to 7. Offset 16 returns the task priority and offset 17 returns the processor priority, each zero-extended. Every other offset returns 0.
- R10: When ack and end-of-interrupt arrive in the same cycle, the end-of-interrupt retires the top vector of the in-service set as it stood before that edge. The acknowledged vector enters the in-service set on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Request strobe for a vector |
| set_vector | input | 8 | Vector to mark pending |
| ack | input | 1 | Core takes the offered vector |
| eoi_write | input | 1 | Retire the top in-service vector |
| tpr_write | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data |
| rd_addr | input | 5 | Read offset |
| rd_data | output | 32 | Read data, combinational |
| offer_valid | output | 1 | A deliverable vector is offered |
| offer_vector | output | 8 | Offered vector |
| err_flag | output | 1 | Sticky reserved-vector request flag |

## Verification
The properties assume that ack is acted on only through offer_valid. They also assume that requests, end-of-interrupt pulses and task-priority writes are single-cycle strobes whose data is meaningful only while the strobe is high. With those assumptions, an offered vector always sits in the pending set and beats the processor priority, and the processor priority never falls below the task priority. The directed stimulus drives each strobe for exactly one clock. It pulses ack both during the post-change bubble and while an offer is shown. It reaches reserved vectors, the top vector 255 and equal-class priority cases only through the ports.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
    parameter int IPU_NVEC      = 256;
    parameter int IPU_WORD      = 32;
    parameter int IPU_NRESV     = 16;
    parameter int IPU_CLASS_LSB = 4;

    typedef enum logic [1:0] {
        RD_PEND = 2'd0,
        RD_ISR  = 2'd1,
        RD_PRIO = 2'd2,
        RD_NONE = 2'd3
    } rd_region_e;
endpackage

// File: rtl/ipu_find_top.sv
module ipu_find_top #(
    parameter int NVEC = 256,
    parameter int WORD = 32
) (
    input  logic [NVEC-1:0]         bits,
    output logic                    found,
    output logic [$clog2(NVEC)-1:0] idx
);
    localparam int NWORD = NVEC / WORD;
    localparam int VW    = $clog2(NVEC);
    localparam int BW    = $clog2(WORD);

    function automatic logic [BW-1:0] msb_of(input logic [WORD-1:0] w);
        logic [BW-1:0] r;
        r = '0;
        for (int b = 0; b < WORD; b++) begin
            if (w[b]) r = BW'(b);
        end
        return r;
    endfunction

    logic [NWORD-1:0] word_nz;
    logic [BW-1:0]    word_msb [NWORD];

    generate
        for (genvar w = 0; w < NWORD; w++) begin : g_word
            assign word_nz[w]  = |bits[w*WORD +: WORD];
            assign word_msb[w] = msb_of(bits[w*WORD +: WORD]);
        end
    endgenerate

    // Scan upward so the highest non-empty word wins.
    always_comb begin
        found = |word_nz;
        idx   = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (word_nz[w]) idx = VW'(w * WORD) + VW'(word_msb[w]);
        end
    end
endmodule

// File: rtl/ipu_ppr_calc.sv
module ipu_ppr_calc #(
    parameter int VW        = 8,
    parameter int CLASS_LSB = 4
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_found,
    input  logic [VW-1:0] isr_top,
    output logic [VW-1:0] ppr
);
    localparam logic [VW-1:0] CLS_MASK = ~VW'((1 << CLASS_LSB) - 1);

    logic [VW-1:0] top_v;
    logic [VW-1:0] top_cls;

    always_comb begin
        top_v   = isr_found ? isr_top : '0;
        top_cls = top_v & CLS_MASK;
        if ((tpr & CLS_MASK) >= top_cls) ppr = tpr;
        else                              ppr = top_cls;
    end
endmodule

// File: rtl/ipu_read_mux.sv
module ipu_read_mux import ipu_pkg::*; #(
    parameter int NVEC = 256,
    parameter int WORD = 32,
    parameter int VW   = 8,
    parameter int AW   = 5
) (
    input  logic [NVEC-1:0] pend,
    input  logic [NVEC-1:0] isr,
    input  logic [VW-1:0]   tpr,
    input  logic [VW-1:0]   ppr,
    input  logic [AW-1:0]   addr,
    output logic [WORD-1:0] data
);
    localparam int NWORD = NVEC / WORD;

    rd_region_e region;
    int         a;

    always_comb begin
        a = int'(addr);
        if (a < NWORD)                region = RD_PEND;
        else if (a < 2 * NWORD)       region = RD_ISR;
        else if (a < 2 * NWORD + 2)   region = RD_PRIO;
        else                          region = RD_NONE;

        data = '0;
        case (region)
            RD_PEND: data = pend[a*WORD +: WORD];
            RD_ISR:  data = isr[(a-NWORD)*WORD +: WORD];
            RD_PRIO: data = (a == 2 * NWORD) ? WORD'(tpr) : WORD'(ppr);
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/intr_prio_unit.sv
module intr_prio_unit import ipu_pkg::*; #(
    parameter int NVEC      = IPU_NVEC,
    parameter int WORD      = IPU_WORD,
    parameter int NRESV     = IPU_NRESV,
    parameter int CLASS_LSB = IPU_CLASS_LSB
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 set_valid,
    input  logic [$clog2(NVEC)-1:0]              set_vector,
    input  logic                                 ack,
    input  logic                                 eoi_write,
    input  logic                                 tpr_write,
    input  logic [$clog2(NVEC)-1:0]              tpr_wdata,
    input  logic [$clog2(2*(NVEC/WORD)+2)-1:0]   rd_addr,
    output logic [WORD-1:0]                      rd_data,
    output logic                                 offer_valid,
    output logic [$clog2(NVEC)-1:0]              offer_vector,
    output logic                                 err_flag
);
    localparam int VW    = $clog2(NVEC);
    localparam int NWORD = NVEC / WORD;
    localparam int AW    = $clog2(2 * NWORD + 2);
    localparam logic [VW-1:0] RESV_LIM = VW'(NRESV);
    localparam logic [VW-1:0] CLS_MASK = ~VW'((1 << CLASS_LSB) - 1);

    typedef struct packed {
        logic [NVEC-1:0] pend;
        logic [NVEC-1:0] isr;
        logic [VW-1:0]   tpr;
        logic [VW-1:0]   ppr;
        logic            offer_v;
        logic [VW-1:0]   offer_vec;
        logic            err;
    } state_t;

    state_t st_d, st_q;

    logic            ack_take, set_legal, eoi_take, changed;
    logic [NVEC-1:0] isr_n;
    logic [VW-1:0]   tpr_n;
    logic            pend_found, isr_found, isr_n_found;
    logic [VW-1:0]   pend_top, isr_top, isr_n_top, ppr_n;

    // Searches over the current pending set, current in-service set and next in-service set.
    ipu_find_top #(.NVEC(NVEC), .WORD(WORD)) u_pend_top (
        .bits(st_q.pend), .found(pend_found), .idx(pend_top));
    ipu_find_top #(.NVEC(NVEC), .WORD(WORD)) u_isr_top (
        .bits(st_q.isr), .found(isr_found), .idx(isr_top));
    ipu_find_top #(.NVEC(NVEC), .WORD(WORD)) u_isr_next (
        .bits(isr_n), .found(isr_n_found), .idx(isr_n_top));

    ipu_ppr_calc #(.VW(VW), .CLASS_LSB(CLASS_LSB)) u_ppr (
        .tpr(tpr_n), .isr_found(isr_n_found), .isr_top(isr_n_top), .ppr(ppr_n));

    ipu_read_mux #(.NVEC(NVEC), .WORD(WORD), .VW(VW), .AW(AW)) u_rd (
        .pend(st_q.pend), .isr(st_q.isr), .tpr(st_q.tpr), .ppr(st_q.ppr),
        .addr(rd_addr), .data(rd_data));

    // Event decode and next in-service / task priority (feeds the priority search).
    always_comb begin
        ack_take  = ack && st_q.offer_v;
        set_legal = set_valid && (set_vector >= RESV_LIM);
        eoi_take  = eoi_write && isr_found;
        changed   = ack_take || set_legal || eoi_take || tpr_write;

        isr_n = st_q.isr;
        if (eoi_take) isr_n[isr_top] = 1'b0;           // retire old top first
        if (ack_take) isr_n[st_q.offer_vec] = 1'b1;    // then admit the taken vector
        tpr_n = tpr_write ? tpr_wdata : st_q.tpr;
    end

    // Assemble the full next state.
    always_comb begin
        st_d     = st_q;
        st_d.isr = isr_n;
        st_d.tpr = tpr_n;
        st_d.ppr = ppr_n;
        if (ack_take)  st_d.pend[st_q.offer_vec] = 1'b0;
        if (set_legal) st_d.pend[set_vector]     = 1'b1;
        if (set_valid && !set_legal) st_d.err    = 1'b1;
        // Offer is computed from settled state only; any change inserts a bubble.
        st_d.offer_v   = pend_found && ((pend_top & CLS_MASK) > st_q.ppr) && !changed;
        st_d.offer_vec = pend_found ? pend_top : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign offer_valid  = st_q.offer_v;
    assign offer_vector = st_q.offer_vec;
    assign err_flag     = st_q.err;

    // State taps for the bound checker.
    logic [NVEC-1:0] pend_cur, isr_cur;
    logic [VW-1:0]   tpr_cur, ppr_cur;
    assign pend_cur = st_q.pend;
    assign isr_cur  = st_q.isr;
    assign tpr_cur  = st_q.tpr;
    assign ppr_cur  = st_q.ppr;
endmodule

// File: rtl/ipu_checker.sv
module ipu_checker #(
    parameter int NVEC      = 256,
    parameter int NRESV     = 16,
    parameter int CLASS_LSB = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    set_valid,
    input logic [$clog2(NVEC)-1:0] set_vector,
    input logic                    ack,
    input logic                    eoi_write,
    input logic                    tpr_write,
    input logic [$clog2(NVEC)-1:0] tpr_wdata,
    input logic                    offer_valid,
    input logic [$clog2(NVEC)-1:0] offer_vector,
    input logic                    err_flag,
    input logic [NVEC-1:0]         pend_cur,
    input logic [NVEC-1:0]         isr_cur,
    input logic [$clog2(NVEC)-1:0] tpr_cur,
    input logic [$clog2(NVEC)-1:0] ppr_cur
);
    localparam int VW = $clog2(NVEC);
    localparam logic [VW-1:0]   CLS_MASK = ~VW'((1 << CLASS_LSB) - 1);
    localparam logic [VW-1:0]   RESV_LIM = VW'(NRESV);
    localparam logic [NVEC-1:0] LOW_MASK = NVEC'((64'd1 << NRESV) - 64'd1);

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_err_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_vector < RESV_LIM) |=> err_flag);

    assert_no_low_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cur & LOW_MASK) == '0);

    assert_offer_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> ((offer_vector & CLS_MASK) > ppr_cur));

    assert_offer_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> pend_cur[offer_vector]);

    assert_ack_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && offer_valid) |=> !offer_valid);

    assert_ack_sets_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && offer_valid) |=> isr_cur[$past(offer_vector)]);

    assert_ppr_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_cur >= tpr_cur);

    assert_eoi_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_write && isr_cur == '0 && !(ack && offer_valid)) |=> isr_cur == '0);

    assert_tpr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_write |=> tpr_cur == $past(tpr_wdata));
endmodule

bind intr_prio_unit ipu_checker #(
    .NVEC(NVEC), .NRESV(NRESV), .CLASS_LSB(CLASS_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
    .ack(ack), .eoi_write(eoi_write), .tpr_write(tpr_write), .tpr_wdata(tpr_wdata),
    .offer_valid(offer_valid), .offer_vector(offer_vector), .err_flag(err_flag),
    .pend_cur(pend_cur), .isr_cur(isr_cur), .tpr_cur(tpr_cur), .ppr_cur(ppr_cur)
);

// File: tb/sim_intr_prio_unit.sv
`timescale 1ns/1ps
module sim_intr_prio_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_valid = 1'b0;
    logic [7:0]  set_vector = '0;
    logic        ack = 1'b0;
    logic        eoi_write = 1'b0;
    logic        tpr_write = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        offer_valid;
    logic [7:0]  offer_vector;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intr_prio_unit u0 (
        .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
        .ack(ack), .eoi_write(eoi_write), .tpr_write(tpr_write), .tpr_wdata(tpr_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .offer_valid(offer_valid),
        .offer_vector(offer_vector), .err_flag(err_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input int addr, input logic [31:0] exp);
        rd_addr = 5'(addr);
        #1;
        chk(req, $sformatf("read offset %0d", addr), rd_data, exp);
    endtask

    task automatic offer_chk(input string req, input logic v, input logic [7:0] vec);
        chk(req, "offer_valid", 32'(offer_valid), 32'(v));
        if (v) chk(req, "offer_vector", 32'(offer_vector), 32'(vec));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_set(input logic [7:0] v);
        set_valid = 1'b1; set_vector = v;
        @(negedge clk);
        set_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi_write = 1'b1;
        @(negedge clk);
        eoi_write = 1'b0;
    endtask

    task automatic write_tpr(input logic [7:0] d);
        tpr_write = 1'b1; tpr_wdata = d;
        @(negedge clk);
        tpr_write = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        rdchk("R1", 0, 32'h0);
        rdchk("R1", 7, 32'h0);
        rdchk("R1", 8, 32'h0);
        rdchk("R1", 15, 32'h0);
        rdchk("R1", 16, 32'h0);
        rdchk("R1", 17, 32'h0);
        rdchk("R9", 20, 32'h0);
        chk("R1", "offer_valid", 32'(offer_valid), 32'h0);
        chk("R1", "err_flag", 32'(err_flag), 32'h0);
    endtask

    task automatic t_set_map();
        do_reset();
        pulse_set(8'h45);
        rdchk("R2", 2, 32'h0000_0020);
        chk("R4", "bubble after change", 32'(offer_valid), 32'h0);
        step();
        offer_chk("R4", 1'b1, 8'h45);
        pulse_set(8'hFF);
        rdchk("R2", 7, 32'h8000_0000);
        step();
        offer_chk("R4", 1'b1, 8'hFF);
        pulse_set(8'h3F);
        rdchk("R9", 1, 32'h8000_0000);
        step();
        offer_chk("R4", 1'b1, 8'hFF);
    endtask

    task automatic t_illegal();
        do_reset();
        pulse_set(8'h0F);
        rdchk("R3", 0, 32'h0);
        chk("R3", "err_flag raised", 32'(err_flag), 32'h1);
        step();
        offer_chk("R3", 1'b0, 8'h0);
        pulse_set(8'h10);
        rdchk("R2", 0, 32'h0001_0000);
        chk("R3", "err_flag sticky", 32'(err_flag), 32'h1);
        step();
        offer_chk("R4", 1'b1, 8'h10);
    endtask

    task automatic t_ack_nest();
        do_reset();
        pulse_set(8'h45);
        pulse_set(8'h81);
        step();
        offer_chk("R4", 1'b1, 8'h81);
        pulse_ack();
        rdchk("R5", 4, 32'h0);
        rdchk("R5", 12, 32'h0000_0002);
        rdchk("R6", 17, 32'h80);
        step();
        offer_chk("R4", 1'b0, 8'h0);
        pulse_set(8'h9A);
        step();
        offer_chk("R4", 1'b1, 8'h9A);
        pulse_ack();
        rdchk("R5", 12, 32'h0400_0002);
        rdchk("R6", 17, 32'h90);
        pulse_eoi();
        rdchk("R7", 12, 32'h0000_0002);
        rdchk("R7", 17, 32'h80);
        pulse_eoi();
        rdchk("R7", 12, 32'h0);
        rdchk("R6", 17, 32'h0);
        step();
        offer_chk("R4", 1'b1, 8'h45);
    endtask

    task automatic t_ack_ignored();
        do_reset();
        pulse_set(8'h50);
        pulse_ack();                 // offer_valid is 0 during the bubble
        rdchk("R5", 10, 32'h0);
        rdchk("R5", 2, 32'h0001_0000);
        offer_chk("R5", 1'b1, 8'h50);
    endtask

    task automatic t_eoi_empty();
        do_reset();
        pulse_set(8'h60);
        step();
        offer_chk("R4", 1'b1, 8'h60);
        pulse_eoi();
        rdchk("R7", 11, 32'h0);
        rdchk("R7", 17, 32'h0);
        rdchk("R7", 3, 32'h0000_0001);
        offer_chk("R7", 1'b1, 8'h60);
    endtask

    task automatic t_tpr();
        do_reset();
        write_tpr(8'h34);
        rdchk("R8", 16, 32'h34);
        rdchk("R8", 17, 32'h34);
        pulse_set(8'h35);
        step();
        offer_chk("R4", 1'b0, 8'h0);
        pulse_set(8'h40);
        step();
        offer_chk("R4", 1'b1, 8'h40);
        pulse_ack();
        rdchk("R6", 17, 32'h40);
        write_tpr(8'h45);
        rdchk("R6", 17, 32'h45);
        write_tpr(8'h57);
        rdchk("R8", 17, 32'h57);
        write_tpr(8'h00);
        rdchk("R6", 17, 32'h40);
    endtask

    task automatic t_ack_eoi();
        do_reset();
        pulse_set(8'h50);
        step();
        pulse_ack();
        rdchk("R5", 17, 32'h50);
        pulse_set(8'h70);
        step();
        offer_chk("R4", 1'b1, 8'h70);
        ack = 1'b1; eoi_write = 1'b1;
        @(negedge clk);
        ack = 1'b0; eoi_write = 1'b0;
        rdchk("R10", 10, 32'h0);
        rdchk("R10", 11, 32'h0001_0000);
        rdchk("R10", 3, 32'h0);
        rdchk("R10", 17, 32'h70);
    endtask

    initial begin
        t_reset();
        t_set_map();
        t_illegal();
        t_ack_nest();
        t_ack_ignored();
        t_eoi_empty();
        t_tpr();
        t_ack_eoi();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule